// File: doc/BRIEF.md
# Strobed Handshake Data Port

This block is one 8-bit peripheral data channel with a three-wire handshake toward the peripheral. The host picks its direction with a mode write. In the receive direction the peripheral drops a strobe to hand over a byte. The block captures the byte, raises a buffer-full flag, and can raise an interrupt once the strobe has returned high. In the transmit direction a host write places a byte on the port pins and pulls an active-low full signal toward the peripheral. The peripheral answers with a low acknowledge, which frees the buffer. After the acknowledge returns high, the block can raise an interrupt.

An enable flip-flop masks the interrupt. The host sets or clears it with a single-bit command that names a bit position and a value. The position this block answers to depends on its direction and on which of two slots in a shared status byte it occupies. A status byte reports the flags at fixed bit positions. The positions that would carry the strobe or acknowledge pin show the enable flag instead.

The strobe and acknowledge inputs are asynchronous and pass through a synchroniser chain. The host strobes are sampled in the block's own clock domain, and the block acts on the edges it sees there.

Top module: `hs_strobe_port`

## Requirements
- R1: After reset the block is in receive direction, with the enable clear, buffer-full low, full signal high, interrupt low, pins not driven, latches zero and status byte 0x00.
- R2: In receive direction, while the synchronised strobe is low, the block copies the port pins into the receive latch (read on host_rdata) and sets buffer-full.
- R3: Buffer-full clears on the rising edge of the host read strobe (chip select held), one cycle after that edge is sampled. It does not clear on the falling edge.
- R4: In receive direction the interrupt rises only while the strobe is high, buffer-full is set, the enable is on and no read is in progress. It clears on the falling edge of the host read, and it never rises with the enable off.
- R5: In transmit direction the rising edge of the host write strobe latches host_wdata onto pin_out and drives the full signal low. pin_oe is high in transmit direction and low in receive direction.
- R6: In transmit direction a low synchronised acknowledge returns the full signal high.
- R7: In transmit direction the interrupt rises only while acknowledge is high, the full signal is high, the enable is on and no write is in progress. It clears on the falling edge of the host write, and it never rises with the enable off.
- R8: The enable flip-flop is written by a bit command only at its own position: 4 in receive and 6 in transmit for slot 0, and 2 in both directions for slot 1. Commands at any other position leave it unchanged.
- R9: A mode write (cfg_dir 0 = receive, 1 = transmit) sets the direction and clears the enable, both flags, the interrupt and both latches.
- R10: Status byte, slot 0: bit 3 interrupt. In receive: bit 5 buffer-full and bit 4 enable. In transmit: bit 7 the full signal and bit 6 enable. Slot 1: bit 0 interrupt, bit 1 buffer-full or full signal, bit 2 enable. All other bits are zero.
- R11: In transmit direction the strobe has no effect. In receive direction a host write changes neither the latch nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Mode write pulse |
| cfg_dir | input | 1 | Direction for mode write: 0 receive, 1 transmit |
| bitcmd_we | input | 1 | Single-bit command pulse |
| bitcmd_pos | input | 3 | Bit position addressed by the command |
| bitcmd_val | input | 1 | Value written by the command |
| host_cs | input | 1 | Host access targets this port |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Receive latch (receive) or transmit latch (transmit) |
| host_status | output | 8 | Status byte |
| pin_in | input | 8 | Port pins from the peripheral |
| pin_out | output | 8 | Port pins toward the peripheral |
| pin_oe | output | 1 | Port pin drive enable |
| stb_n | input | 1 | Peripheral strobe, active low, asynchronous |
| ack_n | input | 1 | Peripheral acknowledge, active low, asynchronous |
| ibf | output | 1 | Receive buffer full |
| obf_n | output | 1 | Transmit buffer full, active low |
| intr | output | 1 | Interrupt request |

## Verification
The receive path is driven with single strobes, back-to-back strobes carrying complementary bytes, and strobes with the enable off. Together these separate the flag from the interrupt and confirm that each transfer replaces the latch. Reads are split into their falling and rising halves so the bench can see that the interrupt clears first and buffer-full clears later. The transmit path is driven with write/acknowledge pairs with the enable on and off, and with stimulus meant for the other direction. That stimulus includes strobes in transmit direction, writes in receive direction and bit commands at the wrong position, and it shows that unrelated inputs are ignored. A mode write from a loaded transmit state confirms that everything returns to its reset values.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic {
        DIR_IN  = 1'b0,
        DIR_OUT = 1'b1
    } dir_e;

    // Bit-command position of the enable flip-flop for a slot and direction.
    function automatic logic [2:0] inte_pos(input int slot, input dir_e dir);
        if (slot == 0) begin
            return (dir == DIR_IN) ? 3'd4 : 3'd6;
        end
        return 3'd2;
    endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int             WIDTH   = 2,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/hs_status.sv
module hs_status #(
    parameter int SLOT = 0
) (
    input  logic       dir_out,
    input  logic       inte,
    input  logic       ibf,
    input  logic       obf_n,
    input  logic       intr,
    output logic [7:0] status
);

    generate
        if (SLOT == 0) begin : g_slot0
            always_comb begin
                status    = 8'h00;
                status[3] = intr;
                if (dir_out) begin
                    status[7] = obf_n;
                    status[6] = inte;
                end else begin
                    status[5] = ibf;
                    status[4] = inte;
                end
            end
        end else begin : g_slot1
            always_comb begin
                status    = 8'h00;
                status[0] = intr;
                status[1] = dir_out ? obf_n : ibf;
                status[2] = inte;
            end
        end
    endgenerate

endmodule

// File: rtl/hs_strobe_port.sv
module hs_strobe_port
    import hs_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SLOT        = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_dir,
    input  logic              bitcmd_we,
    input  logic [2:0]        bitcmd_pos,
    input  logic              bitcmd_val,
    input  logic              host_cs,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic [7:0]        host_status,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_out,
    output logic              pin_oe,
    input  logic              stb_n,
    input  logic              ack_n,
    output logic              ibf,
    output logic              obf_n,
    output logic              intr
);

    localparam int HS_W = 2;

    typedef struct packed {
        dir_e              dir;
        logic              inte;
        logic              ibf;
        logic              obf_n;
        logic              intr;
        logic [DATA_W-1:0] in_lat;
        logic [DATA_W-1:0] out_lat;
        logic              rd_n_q;
        logic              wr_n_q;
    } state_t;

    state_t st_d, st_q;

    logic [HS_W-1:0] hs_s;
    logic            stb_s, ack_s;
    logic            rd_low, rd_fall, rd_rise;
    logic            wr_low, wr_fall, wr_rise;
    logic            en_hit;

    hs_sync #(
        .WIDTH  (HS_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL({HS_W{1'b1}})
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  ({stb_n, ack_n}),
        .q  (hs_s)
    );

    assign stb_s = hs_s[1];
    assign ack_s = hs_s[0];

    always_comb begin
        rd_low  = host_cs && !host_rd_n;
        rd_fall = rd_low && st_q.rd_n_q;
        rd_rise = host_cs && host_rd_n && !st_q.rd_n_q;
        wr_low  = host_cs && !host_wr_n;
        wr_fall = wr_low && st_q.wr_n_q;
        wr_rise = host_cs && host_wr_n && !st_q.wr_n_q;
        en_hit  = bitcmd_we && (bitcmd_pos == inte_pos(SLOT, st_q.dir));

        st_d        = st_q;
        st_d.rd_n_q = host_rd_n;
        st_d.wr_n_q = host_wr_n;

        if (en_hit) begin
            st_d.inte = bitcmd_val;
        end

        if (st_q.dir == DIR_IN) begin
            if (rd_rise) begin
                st_d.ibf = 1'b0;
            end
            if (!stb_s) begin
                st_d.in_lat = pin_in;
                st_d.ibf    = 1'b1;
            end
            if (st_q.intr) begin
                st_d.intr = !(rd_fall || !st_q.inte);
            end else begin
                st_d.intr = stb_s && st_q.ibf && st_q.inte && !rd_low && !rd_rise;
            end
        end else begin
            if (!ack_s) begin
                st_d.obf_n = 1'b1;
            end
            if (wr_rise) begin
                st_d.out_lat = host_wdata;
                st_d.obf_n   = 1'b0;
            end
            if (st_q.intr) begin
                st_d.intr = !(wr_fall || !st_q.inte);
            end else begin
                st_d.intr = ack_s && st_q.obf_n && st_q.inte && !wr_low && !wr_rise;
            end
        end

        if (cfg_we) begin
            st_d.dir     = dir_e'(cfg_dir);
            st_d.inte    = 1'b0;
            st_d.ibf     = 1'b0;
            st_d.obf_n   = 1'b1;
            st_d.intr    = 1'b0;
            st_d.in_lat  = '0;
            st_d.out_lat = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.dir     <= DIR_IN;
            st_q.inte    <= 1'b0;
            st_q.ibf     <= 1'b0;
            st_q.obf_n   <= 1'b1;
            st_q.intr    <= 1'b0;
            st_q.in_lat  <= '0;
            st_q.out_lat <= '0;
            st_q.rd_n_q  <= 1'b1;
            st_q.wr_n_q  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    hs_status #(
        .SLOT(SLOT)
    ) u_status (
        .dir_out(st_q.dir == DIR_OUT),
        .inte   (st_q.inte),
        .ibf    (st_q.ibf),
        .obf_n  (st_q.obf_n),
        .intr   (st_q.intr),
        .status (host_status)
    );

    assign host_rdata = (st_q.dir == DIR_OUT) ? st_q.out_lat : st_q.in_lat;
    assign pin_out    = st_q.out_lat;
    assign pin_oe     = (st_q.dir == DIR_OUT);
    assign ibf        = st_q.ibf;
    assign obf_n      = st_q.obf_n;
    assign intr       = st_q.intr;

    AST_IBF_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(ibf) |-> $past(!stb_s)); // R2

    AST_RD_FALL_CLEARS_INTR: assert property (@(posedge clk) disable iff (rst)
        (rd_fall && st_q.dir == DIR_IN) |=> !intr); // R4

    AST_INTR_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        $rose(intr) |-> $past(st_q.inte)); // R4

    AST_ACK_FREES_BUFFER: assert property (@(posedge clk) disable iff (rst)
        (st_q.dir == DIR_OUT && !ack_s && !wr_rise) |=> obf_n); // R6

    AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (!ibf && obf_n && !intr && !st_q.inte)); // R9

endmodule

// File: tb/sim_hs_strobe_port.sv
module sim_hs_strobe_port;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we, cfg_dir, bitcmd_we, bitcmd_val;
    logic [2:0] bitcmd_pos;
    logic       host_cs, host_rd_n, host_wr_n;
    logic [7:0] host_wdata, host_rdata, host_status, pin_in, pin_out;
    logic       pin_oe, stb_n, ack_n, ibf, obf_n, intr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hs_strobe_port u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_dir(cfg_dir),
        .bitcmd_we(bitcmd_we), .bitcmd_pos(bitcmd_pos), .bitcmd_val(bitcmd_val),
        .host_cs(host_cs), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_status(host_status),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .stb_n(stb_n), .ack_n(ack_n), .ibf(ibf), .obf_n(obf_n), .intr(intr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic dir);
        @(negedge clk); cfg_we = 1'b1; cfg_dir = dir;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic bit_cmd(input logic [2:0] pos, input logic val);
        @(negedge clk); bitcmd_we = 1'b1; bitcmd_pos = pos; bitcmd_val = val;
        @(negedge clk); bitcmd_we = 1'b0;
    endtask

    task automatic strobe(input logic [7:0] data);
        @(negedge clk); pin_in = data; stb_n = 1'b0;
        wait_n(4);
        stb_n = 1'b1;
    endtask

    task automatic host_write(input logic [7:0] data);
        @(negedge clk); host_cs = 1'b1; host_wr_n = 1'b0; host_wdata = data;
        @(negedge clk); host_wr_n = 1'b1;
        @(negedge clk); host_cs = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ibf", ibf, 0);
        chk("R1 obf_n", obf_n, 1);
        chk("R1 intr", intr, 0);
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 status", host_status, 8'h00);
        chk("R1 rdata", host_rdata, 8'h00);
    endtask

    task automatic t_rx_basic();
        set_mode(1'b0);
        bit_cmd(3'd4, 1'b1);
        chk("R8 enable at pos4 in rx", host_status, 8'h10);
        @(negedge clk); pin_in = 8'hA5; stb_n = 1'b0;
        wait_n(4);
        chk("R2 ibf set by strobe", ibf, 1);
        chk("R2 latch data", host_rdata, 8'hA5);
        chk("R4 no intr while strobe low", intr, 0);
        stb_n = 1'b1;
        wait_n(4);
        chk("R4 intr after strobe high", intr, 1);
        chk("R10 rx status", host_status, 8'h38);
        host_cs = 1'b1; host_rd_n = 1'b0;
        wait_n(1);
        chk("R4 intr cleared on read fall", intr, 0);
        chk("R3 ibf held during read", ibf, 1);
        wait_n(2);
        chk("R4 intr stays low during read", intr, 0);
        host_rd_n = 1'b1;
        wait_n(1);
        chk("R3 ibf cleared on read rise", ibf, 0);
        host_cs = 1'b0;
        wait_n(3);
        chk("R4 no intr after buffer empty", intr, 0);
    endtask

    task automatic t_rx_masked();
        bit_cmd(3'd4, 1'b0);
        bit_cmd(3'd6, 1'b1);
        chk("R8 pos6 ignored in rx", host_status, 8'h00);
        strobe(8'h5A);
        wait_n(5);
        chk("R4 masked ibf", ibf, 1);
        chk("R4 masked no intr", intr, 0);
        host_write(8'hFF);
        wait_n(1);
        chk("R11 write ignored in rx data", host_rdata, 8'h5A);
        chk("R11 write ignored in rx obf_n", obf_n, 1);
        chk("R11 write ignored in rx intr", intr, 0);
    endtask

    task automatic t_rx_b2b();
        strobe(8'h3C);
        strobe(8'hC3);
        wait_n(1);
        chk("R2 back-to-back second byte", host_rdata, 8'hC3);
        chk("R2 back-to-back ibf", ibf, 1);
        @(negedge clk); host_cs = 1'b1; host_rd_n = 1'b0;
        @(negedge clk); host_rd_n = 1'b1;
        wait_n(1);
        chk("R3 ibf cleared after b2b", ibf, 0);
        host_cs = 1'b0;
    endtask

    task automatic t_tx();
        set_mode(1'b1);
        chk("R9 tx mode status", host_status, 8'h80);
        chk("R5 pin_oe tx", pin_oe, 1);
        chk("R9 latch cleared", host_rdata, 8'h00);
        bit_cmd(3'd4, 1'b1);
        chk("R8 pos4 ignored in tx", host_status, 8'h80);
        bit_cmd(3'd6, 1'b1);
        wait_n(2);
        chk("R7 intr with empty buffer", intr, 1);
        @(negedge clk); host_cs = 1'b1; host_wr_n = 1'b0; host_wdata = 8'h69;
        wait_n(1);
        chk("R7 intr cleared on write fall", intr, 0);
        chk("R5 obf_n held during write", obf_n, 1);
        host_wr_n = 1'b1;
        wait_n(1);
        chk("R5 obf_n low after write", obf_n, 0);
        chk("R5 pin_out data", pin_out, 8'h69);
        host_cs = 1'b0;
        wait_n(2);
        chk("R7 no intr while full", intr, 0);
        chk("R10 tx status full", host_status, 8'h40);
        @(negedge clk); stb_n = 1'b0; pin_in = 8'h11;
        wait_n(4);
        chk("R11 strobe ignored ibf", ibf, 0);
        chk("R11 strobe ignored data", host_rdata, 8'h69);
        stb_n = 1'b1;
        ack_n = 1'b0;
        wait_n(4);
        chk("R6 ack frees buffer", obf_n, 1);
        chk("R7 no intr while ack low", intr, 0);
        ack_n = 1'b1;
        wait_n(4);
        chk("R7 intr after ack high", intr, 1);
        chk("R10 tx status intr", host_status, 8'hC8);
    endtask

    task automatic t_tx_masked();
        bit_cmd(3'd6, 1'b0);
        wait_n(1);
        chk("R7 intr drops with enable off", intr, 0);
        host_write(8'h96);
        @(negedge clk); ack_n = 1'b0;
        wait_n(4);
        ack_n = 1'b1;
        wait_n(4);
        chk("R6 obf_n after masked transfer", obf_n, 1);
        chk("R7 masked no intr", intr, 0);
    endtask

    task automatic t_mode_clear();
        bit_cmd(3'd6, 1'b1);
        host_write(8'hE7);
        chk("R5 loaded before mode write", obf_n, 0);
        set_mode(1'b0);
        chk("R9 status cleared", host_status, 8'h00);
        chk("R9 obf_n cleared", obf_n, 1);
        chk("R9 intr cleared", intr, 0);
        chk("R9 pin_oe rx", pin_oe, 0);
        chk("R9 rx latch cleared", host_rdata, 8'h00);
    endtask

    initial begin
        rst = 1'b1; cfg_we = 0; cfg_dir = 0; bitcmd_we = 0; bitcmd_pos = 0;
        bitcmd_val = 0; host_cs = 0; host_rd_n = 1; host_wr_n = 1;
        host_wdata = 0; pin_in = 0; stb_n = 1; ack_n = 1;
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        t_reset();
        t_rx_basic();
        t_rx_masked();
        t_rx_b2b();
        t_tx();
        t_tx_masked();
        t_mode_clear();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule